// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Controller

This block sequences an external dual-slope analog front end (integrator, analog switch and comparator) and times the result in digital logic. A start request carries a 16-bit control value. The block then drives the switch-select line so that the unknown input feeds the integrator. It counts qualifying ticks only while the comparator reports the integrator past its threshold. After a fixed number of ticks it switches the integrator back to the reference and times the run-down until the comparator releases. The count register is preloaded with the negated control value in both phases, so the run-up ends when the register passes its all-ones value. The latched run-down value comes out biased: adding the control value back gives the run-down length in ticks.

Counting is paced by an external count-enable tick, normally taken from a clock divider. With a 5 MHz clock divided by two, the tick period is 400 ns, and a control value of 60000 gives a 24 ms integration period. The comparator input passes through a synchronizer, and its polarity can be inverted. A tick-based timeout ends a conversion whose comparator never settles and raises an underrange flag. A run-down longer than the run-up raises an overrange flag and latches no result.

Top module: `dslope_ctrl`

## Requirements
- R1: After reset, sel_input_o is 0 (integrator on the reference), busy_o, done_o, underrange_o and overrange_o are 0, and result_o is 0.
- R2: A start_i pulse while idle makes sel_input_o and busy_o 1 from the next cycle, and clears underrange_o and overrange_o.
- R3: During the run-up, only ticks taken while the comparator is active advance the count. sel_input_o returns to 0 on exactly the ctrl_i-th such tick. Ticks taken before the comparator first goes active, or while it is inactive in between, do not count.
- R4: In the run-down, the comparator going inactive latches result_o = (n - ctrl_i) mod 65536, where n is the number of active ticks in the run-down. done_o is high for exactly one cycle, and busy_o falls. The largest valid value is 0xFFFF, at n = ctrl_i - 1.
- R5: The comparator is active when cmp_i XOR cmp_invert_i is 1. With cmp_invert_i = 1, a low comparator level counts.
- R6: The run-down tick that would carry the count past 0xFFFF (n = ctrl_i) sets overrange_o, ends the conversion with busy_o = 0, gives no done_o pulse and leaves result_o unchanged.
- R7: The TIMEOUT_TICKS-th tick after an accepted start, with the conversion still running, sets underrange_o, drops busy_o and sel_input_o, and gives no done_o pulse.
- R8: A start_i pulse while busy_o is 1 is ignored: the control value and phase timing of the running conversion are kept.
- R9: underrange_o and overrange_o stay set until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request pulse |
| ctrl_i | input | 16 | Run-up length in ticks, captured on an accepted start |
| tick_i | input | 1 | Prescaled count enable |
| cmp_i | input | 1 | Raw comparator level (asynchronous) |
| cmp_invert_i | input | 1 | 1 = comparator is active low |
| sel_input_o | output | 1 | 1 = integrator on unknown input, 0 = on reference |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 16 | Biased run-down count |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| underrange_o | output | 1 | Timeout flag, held until next start |
| overrange_o | output | 1 | Run-down overflow flag, held until next start |

## Verification
Conversions are driven with idle ticks before the comparator first becomes active. Some runs also pause the comparator in the middle of the run-up. Together these show whether the count is gated by the comparator or free-running from the start request. Run-down lengths of zero, a middle value and ctrl-1 check the bias arithmetic at its low end and at the all-ones limit. A run-down of exactly ctrl ticks must take the overrange path instead. One conversion runs with inverted polarity, one receives a second start request partway through, and two runs exercise the timeout: one with the comparator never active and one stuck in the run-down. These separate the error exits from normal completion.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_INTEG   = 2'd1,
    PH_DEINTEG = 2'd2
  } phase_t;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic stg_q;
      always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= 1'b0;
        else        stg_q <= d_i;
      end
      assign q_o = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0] stg_q;
      always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d_i};
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dsc_watchdog.sv
module dsc_watchdog #(
  parameter int LIMIT = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] ticks_q;
  logic         at_last;

  assign at_last  = (ticks_q == LAST);
  assign expire_o = run_i && tick_i && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)                        ticks_q <= '0;
    else if (clear_i)                  ticks_q <= '0;
    else if (run_i && tick_i && !at_last) ticks_q <= ticks_q + 1'b1;
  end

  // R7
  wd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (ticks_q <= LAST));

  // R7
  wd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (ticks_q == '0));
endmodule

// File: rtl/dsc_seq.sv
module dsc_seq
  import dsc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] ctrl_i,
  input  logic          act_i,
  input  logic          tick_i,
  input  logic          wd_exp_i,
  output phase_t        phase_o,
  output logic          accept_o,
  output logic [CW-1:0] result_o,
  output logic          done_o,
  output logic          under_o,
  output logic          over_o
);
  localparam logic [CW-1:0] TERM = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  function automatic logic [CW-1:0] bias_of(input logic [CW-1:0] v);
    return ~v + ONE;
  endfunction

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] ctrl_q;
  logic          adv;
  logic          at_term;

  assign phase_o  = phase_q;
  assign accept_o = (phase_q == PH_IDLE) && start_i;
  assign adv      = tick_i && act_i;
  assign at_term  = (cnt_q == TERM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      ctrl_q   <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
      under_o  <= 1'b0;
      over_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            cnt_q   <= bias_of(ctrl_i);
            ctrl_q  <= ctrl_i;
            under_o <= 1'b0;
            over_o  <= 1'b0;
            phase_q <= PH_INTEG;
          end
        end
        PH_INTEG: begin
          if (wd_exp_i) begin
            under_o <= 1'b1;
            phase_q <= PH_IDLE;
          end else if (adv) begin
            if (at_term) begin
              cnt_q   <= bias_of(ctrl_q);
              phase_q <= PH_DEINTEG;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end
        end
        PH_DEINTEG: begin
          if (!act_i) begin
            result_o <= cnt_q;
            done_o   <= 1'b1;
            phase_q  <= PH_IDLE;
          end else if (wd_exp_i) begin
            under_o <= 1'b1;
            phase_q <= PH_IDLE;
          end else if (tick_i) begin
            if (at_term) begin
              over_o  <= 1'b1;
              phase_q <= PH_IDLE;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R3
  cnt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && !adv) |=> $stable(cnt_q));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  over_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(over_o) |-> (!done_o && $stable(result_o)));

  // R7
  wd_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_exp_i && phase_q == PH_INTEG) |=> (phase_q == PH_IDLE && under_o));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && start_i && !tick_i && act_i) |=> (phase_q != PH_IDLE));
endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
  import dsc_pkg::*;
#(
  parameter int CW            = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int TIMEOUT_TICKS = 200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] ctrl_i,
  input  logic          tick_i,
  input  logic          cmp_i,
  input  logic          cmp_invert_i,
  output logic          sel_input_o,
  output logic          busy_o,
  output logic [CW-1:0] result_o,
  output logic          done_o,
  output logic          underrange_o,
  output logic          overrange_o
);
  logic   cmp_sync;
  logic   cmp_act;
  logic   wd_exp;
  logic   accept;
  phase_t phase;

  dsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_i),
    .q_o   (cmp_sync)
  );

  assign cmp_act = cmp_sync ^ cmp_invert_i;

  dsc_watchdog #(.LIMIT(TIMEOUT_TICKS)) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept),
    .run_i    (busy_o),
    .tick_i   (tick_i),
    .expire_o (wd_exp)
  );

  dsc_seq #(.CW(CW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ctrl_i   (ctrl_i),
    .act_i    (cmp_act),
    .tick_i   (tick_i),
    .wd_exp_i (wd_exp),
    .phase_o  (phase),
    .accept_o (accept),
    .result_o (result_o),
    .done_o   (done_o),
    .under_o  (underrange_o),
    .over_o   (overrange_o)
  );

  assign sel_input_o = (phase == PH_INTEG);
  assign busy_o      = (phase != PH_IDLE);

  // R2
  sel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_input_o) |-> $past(start_i));

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !sel_input_o));

  // R7
  under_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrange_o) |-> (!busy_o && !done_o));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrange_o && !start_i) |=> underrange_o);
endmodule

// File: tb/dslope_ctrl_test.sv
module dslope_ctrl_test;
  localparam int TMO = 120;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] ctrl_i = '0;
  logic        tick_i = 1'b0;
  logic        cmp_i = 1'b0;
  logic        cmp_invert_i = 1'b0;
  logic        sel_input_o, busy_o, done_o, underrange_o, overrange_o;
  logic [15:0] result_o;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  bit finished = 1'b0;
  logic [15:0] last_res = '0;

  always #2 clk = ~clk;

  dslope_ctrl #(.TIMEOUT_TICKS(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_i(ctrl_i),
    .tick_i(tick_i), .cmp_i(cmp_i), .cmp_invert_i(cmp_invert_i),
    .sel_input_o(sel_input_o), .busy_o(busy_o), .result_o(result_o),
    .done_o(done_o), .underrange_o(underrange_o), .overrange_o(overrange_o)
  );

  always @(negedge clk) if (rst_n && done_o) done_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic set_cmp(input logic v);
    cmp_i = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_start(input logic [15:0] v);
    @(negedge clk) begin start_i = 1'b1; ctrl_i = v; end
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sel", sel_input_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_cnt, 0);
    chk("R1 under", underrange_o, 0);
    chk("R1 over", overrange_o, 0);
    chk("R1 result", result_o, 0);
  endtask

  task automatic run_conv(input int ctrl, input int pre, input int pause,
                          input int n, input logic inv, input bit extra);
    int d0;
    logic [15:0] exp;
    cmp_invert_i = inv;
    set_cmp(inv);
    d0 = done_cnt;
    pulse_start(16'(ctrl));
    chk("R2 sel after start", sel_input_o, 1);
    chk("R2 busy after start", busy_o, 1);
    chk("R2 flags cleared", {underrange_o, overrange_o}, 0);
    tick(pre);
    set_cmp(~inv);
    if (extra) begin
      pulse_start(16'd5);
      chk("R8 busy kept", busy_o, 1);
    end
    if (pause > 0) begin
      tick(ctrl / 2);
      set_cmp(inv);
      tick(pause);
      set_cmp(~inv);
      tick(ctrl - ctrl / 2 - 1);
    end else begin
      tick(ctrl - 1);
    end
    chk(extra ? "R8 run-up keeps first value" : (inv ? "R5 run-up one short" : "R3 run-up one short"),
        sel_input_o, 1);
    tick(1);
    chk(inv ? "R5 run-up end" : "R3 run-up end", sel_input_o, 0);
    chk("R3 busy in run-down", busy_o, 1);
    tick(n);
    set_cmp(inv);
    repeat (2) @(negedge clk);
    exp = 16'(n - ctrl);
    chk("R4 done pulse", done_cnt, d0 + 1);
    chk(inv ? "R5 result" : "R4 result", result_o, exp);
    chk("R4 busy low", busy_o, 0);
    last_res = exp;
  endtask

  task automatic t_over();
    int d0;
    cmp_invert_i = 1'b0;
    set_cmp(1'b0);
    d0 = done_cnt;
    pulse_start(16'd8);
    set_cmp(1'b1);
    tick(8);
    chk("R6 run-up end", sel_input_o, 0);
    tick(7);
    chk("R6 busy before wrap", busy_o, 1);
    chk("R6 no flag before wrap", overrange_o, 0);
    tick(1);
    chk("R6 overrange set", overrange_o, 1);
    chk("R6 busy low", busy_o, 0);
    set_cmp(1'b0);
    repeat (2) @(negedge clk);
    chk("R6 no done", done_cnt, d0);
    chk("R6 result kept", result_o, last_res);
    tick(3);
    chk("R9 overrange held", overrange_o, 1);
  endtask

  task automatic t_under_idle();
    int d0;
    cmp_invert_i = 1'b0;
    set_cmp(1'b0);
    d0 = done_cnt;
    pulse_start(16'd10);
    tick(TMO - 1);
    chk("R7 busy before timeout", busy_o, 1);
    chk("R7 no flag before timeout", underrange_o, 0);
    tick(1);
    chk("R7 underrange set", underrange_o, 1);
    chk("R7 busy low", busy_o, 0);
    chk("R7 sel low", sel_input_o, 0);
    chk("R7 no done", done_cnt, d0);
  endtask

  task automatic t_under_stuck();
    int d0;
    cmp_invert_i = 1'b0;
    set_cmp(1'b0);
    d0 = done_cnt;
    pulse_start(16'd70);
    set_cmp(1'b1);
    tick(70);
    chk("R7 in run-down", sel_input_o, 0);
    tick(TMO - 71);
    chk("R7 still busy", busy_o, 1);
    tick(1);
    chk("R7 stuck underrange", underrange_o, 1);
    chk("R7 stuck busy low", busy_o, 0);
    set_cmp(1'b0);
    repeat (2) @(negedge clk);
    chk("R7 stuck no done", done_cnt, d0);
    chk("R7 result kept", result_o, last_res);
    tick(2);
    chk("R9 underrange held", underrange_o, 1);
  endtask

  initial begin
    repeat (TMO * 1000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    run_conv(10, 3, 0, 4, 1'b0, 1'b0);
    run_conv(20, 0, 0, 19, 1'b0, 1'b0);
    run_conv(16, 2, 0, 0, 1'b0, 1'b0);
    run_conv(12, 1, 3, 5, 1'b1, 1'b0);
    run_conv(10, 0, 0, 2, 1'b0, 1'b1);
    t_over();
    run_conv(9, 0, 0, 3, 1'b0, 1'b0);
    t_under_idle();
    t_under_stuck();
    run_conv(6, 1, 2, 5, 1'b0, 1'b0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule